// File: doc/BRIEF.md
# Precharge-Capable DMA Burst Sequencer

This block is a bus master for a host bus clocked by two quadrature phase clocks, E and Q. On a start pulse it latches a target start address, a burst length and a transfer style. It then raises a bus request and waits one whole host cycle with the grant present. After that it moves one byte per host cycle, back to back, into or out of host memory. Write bytes arrive on a valid/ready byte stream. Read bytes leave on a valid-only stream, since a host bus cycle cannot be stretched.

Writes come in two styles. In direct style, the target address, the data byte and an active-low write level are held for the whole host cycle. In precharge style, each host cycle has two phases. Up to the Q rising edge, the engine drives the byte onto the data lines while it shows a read at a park address. The park address sits in a region where the memory controller keeps its data pins off the bus. From the Q rising edge to the end of the cycle, the engine releases the data lines, drops R/W and puts out the real target address. This lets a buffered, floating bus segment carry the byte into the write. Because the parked charge only lasts a short time, both phases always fall in the same host cycle.

E and Q are sampled on the local clock `clk`. Every host-cycle boundary is the sampled falling edge of E. Every phase change inside a cycle is the sampled rising edge of Q.

Top module: `dps_precharge_seq`

## Requirements
- R1: While reset is low, bus_req, busy, done, data_oe, src_ready and rd_valid are 0 and rw_n is 1.
- R2: A start pulse while idle latches start_wr, start_pre, park_sel, start_addr and start_len. On the next clock, busy and bus_req are 1. busy stays 1 until the clock after done.
- R3: A start pulse while busy is ignored. The running burst keeps its length, addresses and style, and no second burst follows.
- R4: After bus_req rises, transfers wait for one E fall to pass. After that, the first transfer cycle opens at the first E fall at which bus_grant is 1. Until then, the engine drives nothing and rw_n stays 1.
- R5: In a direct-style write cycle, addr_out carries the target, data_out carries the byte, data_oe is 1 and rw_n is 0 from one E fall to the next.
- R6: In a precharge-style write cycle, before the cycle's Q rise: addr_out carries the park address, data_oe is 1, data_out carries the byte and rw_n is 1. From the Q rise to the next E fall: addr_out carries the target, data_oe is 0 and rw_n is 0.
- R7: park_sel picks the park address: 0 gives 16'hFF00, 1 gives 16'hFFE0, 2 gives 16'hFFF0 and 3 gives 16'hFF00.
- R8: In a read burst, each cycle shows the target with rw_n=1 and data_oe=0. data_in is sampled at the E fall that closes the cycle. That sample appears on rd_data with a one-clock rd_valid pulse on the next clock. Bytes come out in address order.
- R9: The burst moves start_len bytes, or 16 bytes when start_len is 0. The target starts at start_addr and steps by one per byte, wrapping modulo 2^16.
- R10: A write byte is taken when src_valid and src_ready are both 1. At most one byte is held, and src_ready is 0 while one is held or once the burst's bytes have all been taken. A write cycle that opens with no byte held is an idle cycle: rw_n=1, data_oe=0, and it does not count toward the burst.
- R11: At the E fall that closes the last byte's cycle, on the next clock bus_req falls and done pulses for exactly one clock. On the clock after that, busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| e_clk | input | 1 | Host E phase clock |
| q_clk | input | 1 | Host Q phase clock, a quarter cycle ahead of E |
| start | input | 1 | One-clock burst start pulse |
| start_wr | input | 1 | 1 = write burst, 0 = read burst |
| start_pre | input | 1 | 1 = precharge write style, 0 = direct |
| park_sel | input | 2 | Park region select for precharge |
| start_addr | input | 16 | First target address |
| start_len | input | 4 | Burst length, 0 means 16 |
| src_valid | input | 1 | Write byte stream valid |
| src_ready | output | 1 | Write byte stream ready |
| src_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte valid pulse |
| rd_data | output | 8 | Read byte |
| bus_req | output | 1 | Host bus request |
| bus_grant | input | 1 | Host bus grant |
| addr_out | output | 16 | Host address bus |
| data_out | output | 8 | Host data bus output value |
| data_oe | output | 1 | Host data bus output enable |
| rw_n | output | 1 | Host R/W, 1 = read, 0 = write |
| data_in | input | 8 | Host data bus input |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-clock end-of-burst pulse |

## Verification
The assertions watch rules that hold on every cycle. The data lines are driven with R/W high only at a park address. Nothing is driven and no byte is taken without a request. done is a single pulse with the request already dropped and busy clearing right after. Read pulses never run together. The bench's reference model covers what depends on history and on the host clock phase. That includes the exact clock at which each phase switches, the wait for one whole cycle before the first transfer, and idle cycles when the byte stream stalls. It also covers the length-zero burst of sixteen with address wrap, the park address chosen by each select value, and a start pulse that lands mid-burst and has to be dropped.

// File: rtl/dps_pkg.sv
package dps_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_ARM,
    ST_XFER,
    ST_FIN
  } dps_state_e;
endpackage

// File: rtl/dps_edges.sv
// Samples the host phase clocks and flags the two edges the sequencer uses.
module dps_edges #(
  parameter int SYNC_STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic e_clk,
  input  logic q_clk,
  output logic e_fall,
  output logic q_rise
);
  localparam int DEPTH = SYNC_STAGES + 1;

  logic [DEPTH-1:0] e_pipe, q_pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_pipe <= '0;
      q_pipe <= '0;
    end else begin
      e_pipe <= {e_pipe[DEPTH-2:0], e_clk};
      q_pipe <= {q_pipe[DEPTH-2:0], q_clk};
    end
  end

  assign e_fall = e_pipe[DEPTH-1] & ~e_pipe[DEPTH-2];
  assign q_rise = ~q_pipe[DEPTH-1] & q_pipe[DEPTH-2];
endmodule

// File: rtl/dps_fetch.sv
// One-entry holding slot between the byte stream and the bus cycles.
module dps_fetch #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic              en,
  input  logic              take,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  output logic              hold_full,
  output logic [DATA_W-1:0] hold_byte
);
  logic [CNT_W-1:0] pend;

  assign src_ready = en && !hold_full && (pend != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_byte <= '0;
      pend      <= '0;
    end else if (load) begin
      hold_full <= 1'b0;
      pend      <= load_cnt;
    end else begin
      if (take) hold_full <= 1'b0;
      if (src_valid && src_ready) begin
        hold_full <= 1'b1;
        hold_byte <= src_data;
        pend      <= pend - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/dps_seq.sv
// Burst state machine: request, one armed cycle, transfer cycles, finish.
module dps_seq
  import dps_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int LEN_W  = 4,
  parameter int CNT_W  = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_wr,
  input  logic              start_pre,
  input  logic [1:0]        park_sel,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  start_len,
  input  logic              bus_grant,
  input  logic              e_fall,
  input  logic              q_rise,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_byte,
  input  logic [DATA_W-1:0] data_in,
  output dps_state_e        state,
  output logic              act,
  output logic              late,
  output logic [DATA_W-1:0] cur_byte,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic              mode_wr,
  output logic              mode_pre,
  output logic [1:0]        sel_q,
  output logic              load,
  output logic [CNT_W-1:0]  load_cnt,
  output logic              take,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic [CNT_W-1:0] left, left_after;
  logic             open_act, begin_now;

  assign load       = (state == ST_IDLE) && start;
  assign load_cnt   = (start_len == '0) ? {1'b1, {LEN_W{1'b0}}} : {1'b0, start_len};
  assign left_after = act ? left - CNT_W'(1) : left;
  assign open_act   = !mode_wr || hold_full;
  assign begin_now  = e_fall && (((state == ST_ARM) && bus_grant) ||
                                 ((state == ST_XFER) && (left_after != '0)));
  assign take       = begin_now && mode_wr && hold_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      act      <= 1'b0;
      late     <= 1'b0;
      cur_byte <= '0;
      tgt_addr <= '0;
      mode_wr  <= 1'b0;
      mode_pre <= 1'b0;
      sel_q    <= '0;
      left     <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (e_fall)      late <= 1'b0;
      else if (q_rise) late <= 1'b1;
      if (take) cur_byte <= hold_byte;
      unique case (state)
        ST_IDLE: if (start) begin
          state    <= ST_REQ;
          mode_wr  <= start_wr;
          mode_pre <= start_pre;
          sel_q    <= park_sel;
          tgt_addr <= start_addr;
          left     <= load_cnt;
          act      <= 1'b0;
        end
        ST_REQ: if (e_fall) state <= ST_ARM;
        ST_ARM: if (e_fall && bus_grant) begin
          state <= ST_XFER;
          act   <= open_act;
        end
        ST_XFER: if (e_fall) begin
          if (act) begin
            tgt_addr <= tgt_addr + ADDR_W'(1);
            if (!mode_wr) begin
              rd_valid <= 1'b1;
              rd_data  <= data_in;
            end
          end
          left <= left_after;
          if (left_after == '0) begin
            state <= ST_FIN;
            act   <= 1'b0;
          end else begin
            act <= open_act;
          end
        end
        ST_FIN: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dps_drive.sv
// Host bus output selection by style and phase.
module dps_drive
  import dps_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] PARK_IO  = 16'hFF00,
  parameter logic [ADDR_W-1:0] PARK_RSV = 16'hFFE0,
  parameter logic [ADDR_W-1:0] PARK_VEC = 16'hFFF0
) (
  input  dps_state_e        state,
  input  logic              act,
  input  logic              late,
  input  logic              mode_wr,
  input  logic              mode_pre,
  input  logic [1:0]        sel_q,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [DATA_W-1:0] cur_byte,
  output logic [ADDR_W-1:0] addr_out,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              rw_n
);
  logic [ADDR_W-1:0] park_addr;

  always_comb begin
    unique case (sel_q)
      2'd1:    park_addr = PARK_RSV;
      2'd2:    park_addr = PARK_VEC;
      default: park_addr = PARK_IO;
    endcase
  end

  always_comb begin
    addr_out = '0;
    data_oe  = 1'b0;
    rw_n     = 1'b1;
    if (state == ST_XFER) begin
      addr_out = tgt_addr;
      if (act && mode_wr) begin
        if (!mode_pre) begin
          data_oe = 1'b1;
          rw_n    = 1'b0;
        end else if (!late) begin
          addr_out = park_addr;
          data_oe  = 1'b1;
        end else begin
          rw_n = 1'b0;
        end
      end
    end
    data_out = data_oe ? cur_byte : '0;
  end
endmodule

// File: rtl/dps_precharge_seq.sv
module dps_precharge_seq
  import dps_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int LEN_W       = 4,
  parameter int SYNC_STAGES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              e_clk,
  input  logic              q_clk,
  input  logic              start,
  input  logic              start_wr,
  input  logic              start_pre,
  input  logic [1:0]        park_sel,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  start_len,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [DATA_W-1:0] src_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic [ADDR_W-1:0] addr_out,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              rw_n,
  input  logic [DATA_W-1:0] data_in,
  output logic              busy,
  output logic              done
);
  localparam int CNT_W = LEN_W + 1;

  dps_state_e        state;
  logic              e_fall, q_rise, act, late, mode_wr, mode_pre;
  logic              load, take, hold_full;
  logic [1:0]        sel_q;
  logic [CNT_W-1:0]  load_cnt;
  logic [DATA_W-1:0] hold_byte, cur_byte;
  logic [ADDR_W-1:0] tgt_addr;

  dps_edges #(.SYNC_STAGES(SYNC_STAGES)) u_edges (
    .clk(clk), .rst_n(rst_n), .e_clk(e_clk), .q_clk(q_clk),
    .e_fall(e_fall), .q_rise(q_rise)
  );

  dps_fetch #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .load(load), .load_cnt(load_cnt),
    .en(mode_wr && (state inside {ST_REQ, ST_ARM, ST_XFER})),
    .take(take), .src_valid(src_valid), .src_data(src_data),
    .src_ready(src_ready), .hold_full(hold_full), .hold_byte(hold_byte)
  );

  dps_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_wr(start_wr),
    .start_pre(start_pre), .park_sel(park_sel), .start_addr(start_addr),
    .start_len(start_len), .bus_grant(bus_grant), .e_fall(e_fall),
    .q_rise(q_rise), .hold_full(hold_full), .hold_byte(hold_byte),
    .data_in(data_in), .state(state), .act(act), .late(late),
    .cur_byte(cur_byte), .tgt_addr(tgt_addr), .mode_wr(mode_wr),
    .mode_pre(mode_pre), .sel_q(sel_q), .load(load), .load_cnt(load_cnt),
    .take(take), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  dps_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
    .state(state), .act(act), .late(late), .mode_wr(mode_wr),
    .mode_pre(mode_pre), .sel_q(sel_q), .tgt_addr(tgt_addr),
    .cur_byte(cur_byte), .addr_out(addr_out), .data_out(data_out),
    .data_oe(data_oe), .rw_n(rw_n)
  );

  assign bus_req = state inside {ST_REQ, ST_ARM, ST_XFER};
  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_FIN);
endmodule

// File: rtl/dps_chk.sv
module dps_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              busy,
  input logic              done,
  input logic              src_ready,
  input logic              rd_valid,
  input logic              data_oe,
  input logic              rw_n,
  input logic [ADDR_W-1:0] addr_out
);
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_quiet_in_reset: assert (!bus_req && !busy && !done && !data_oe && rw_n && !src_ready && !rd_valid);
    end
  end

  a_r2_req_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> busy);
  a_r5_drive_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> bus_req);
  a_r6_park_region: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && rw_n) |-> (&addr_out[ADDR_W-1:ADDR_W-8]));
  a_r8_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  a_r10_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> bus_req);
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r11_req_released: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_req);
  a_r11_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

bind dps_precharge_seq dps_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .busy(busy), .done(done),
  .src_ready(src_ready), .rd_valid(rd_valid), .data_oe(data_oe),
  .rw_n(rw_n), .addr_out(addr_out)
);

// File: tb/dps_precharge_seq_tb.sv
module dps_precharge_seq_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, e_clk = 1'b0, q_clk = 1'b0;
  logic start = 1'b0, start_wr = 1'b0, start_pre = 1'b0, bus_grant = 1'b1;
  logic [1:0] park_sel = '0;
  logic [15:0] start_addr = '0;
  logic [3:0] start_len = '0;
  logic src_valid = 1'b0, src_ready, rd_valid, bus_req, data_oe, rw_n, busy, done;
  logic [7:0] src_data = '0, rd_data, data_out, data_in;
  logic [15:0] addr_out;

  assign data_in = addr_out[7:0] ^ 8'h5A;

  dps_precharge_seq u_dut (
    .clk(clk), .rst_n(rst_n), .e_clk(e_clk), .q_clk(q_clk), .start(start),
    .start_wr(start_wr), .start_pre(start_pre), .park_sel(park_sel),
    .start_addr(start_addr), .start_len(start_len), .src_valid(src_valid),
    .src_ready(src_ready), .src_data(src_data), .rd_valid(rd_valid),
    .rd_data(rd_data), .bus_req(bus_req), .bus_grant(bus_grant),
    .addr_out(addr_out), .data_out(data_out), .data_oe(data_oe), .rw_n(rw_n),
    .data_in(data_in), .busy(busy), .done(done)
  );

  int vectors = 0, miscompares = 0, tick = 0;
  bit gap_mode = 1'b0;
  logic [7:0] src_q[$];

  // reference model state
  int m_st = 0, m_left = 0, m_fetch = 0, m_addr = 0, m_sel = 0;
  bit m_wr = 0, m_pre = 0, m_hf = 0, m_act = 0, m_late = 0, m_rdv = 0;
  bit m_es = 0, m_ed = 0, m_qs = 0, m_qd = 0;
  logic [7:0] m_hold = 0, m_cur = 0, m_rdd = 0;

  // scenario monitors
  int wr_seen = 0, rd_seen = 0, busy_after = 0;
  logic [15:0] last_park = 0, last_wr = 0, prev_addr = 0;
  logic prev_rw = 1'b1;

  task automatic chk(input bit ok, input string what, input string tag,
                     input logic [31:0] act_v, input logic [31:0] exp_v);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h at tick %0d", tag, what, act_v, exp_v, tick);
    end
  endtask

  function automatic bit m_ready();
    return (m_st >= 1 && m_st <= 3) && m_wr && !m_hf && (m_fetch != 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_left = 0; m_fetch = 0; m_addr = 0; m_sel = 0;
      m_wr = 0; m_pre = 0; m_hf = 0; m_act = 0; m_late = 0; m_rdv = 0;
      m_es = 0; m_ed = 0; m_qs = 0; m_qd = 0;
    end else begin
      bit ef, qr, acc, opn;
      int la;
      ef  = m_ed && !m_es;
      qr  = !m_qd && m_qs;
      acc = src_valid && m_ready();
      opn = !m_wr || m_hf;
      m_rdv = 0;
      if (ef) m_late = 0; else if (qr) m_late = 1;
      case (m_st)
        0: if (start) begin
          m_st = 1; m_wr = start_wr; m_pre = start_pre; m_sel = park_sel;
          m_addr = start_addr; m_left = (start_len == 0) ? 16 : start_len;
          m_fetch = m_left; m_hf = 0; m_act = 0;
        end
        1: if (ef) m_st = 2;
        2: if (ef && bus_grant) begin
          m_st = 3; m_act = opn;
          if (m_wr && m_hf) begin m_cur = m_hold; m_hf = 0; end
        end
        3: if (ef) begin
          la = m_act ? m_left - 1 : m_left;
          if (m_act) begin
            if (!m_wr) begin m_rdv = 1; m_rdd = 8'(m_addr) ^ 8'h5A; end
            m_addr = (m_addr + 1) & 'hFFFF;
          end
          m_left = la;
          if (la == 0) begin m_st = 4; m_act = 0; end
          else begin
            m_act = opn;
            if (m_wr && m_hf) begin m_cur = m_hold; m_hf = 0; end
          end
        end
        default: m_st = 0;
      endcase
      if (acc) begin
        m_hf = 1; m_hold = src_data; m_fetch--;
        void'(src_q.pop_front());
      end
      m_ed = m_es; m_es = e_clk; m_qd = m_qs; m_qs = q_clk;
    end
  end

  // compare on every clock, then drive host clocks and the byte stream
  always @(negedge clk) begin
    if (rst_n) begin
      logic [15:0] e_addr;
      logic [7:0] e_data;
      bit e_oe, e_rw;
      string tg;
      tg = !m_wr ? "R8" : (m_pre ? "R6" : "R5");
      e_addr = 0; e_data = 0; e_oe = 0; e_rw = 1;
      if (m_st == 3) begin
        e_addr = 16'(m_addr);
        if (m_act && m_wr) begin
          if (!m_pre) begin e_oe = 1; e_rw = 0; end
          else if (!m_late) begin
            e_addr = (m_sel == 1) ? 16'hFFE0 : (m_sel == 2) ? 16'hFFF0 : 16'hFF00;
            e_oe = 1;
          end else e_rw = 0;
        end
      end
      if (e_oe) e_data = m_cur;
      chk(bus_req == (m_st >= 1 && m_st <= 3), "bus_req", "R4", 32'(bus_req), 32'(m_st));
      chk(busy == (m_st != 0), "busy", "R2", 32'(busy), 32'(m_st != 0));
      chk(done == (m_st == 4), "done", "R11", 32'(done), 32'(m_st == 4));
      chk(src_ready == m_ready(), "src_ready", "R10", 32'(src_ready), 32'(m_ready()));
      chk(addr_out == e_addr, "addr_out", tg, 32'(addr_out), 32'(e_addr));
      chk(rw_n == e_rw, "rw_n", tg, 32'(rw_n), 32'(e_rw));
      chk(data_oe == e_oe, "data_oe", tg, 32'(data_oe), 32'(e_oe));
      chk(data_out == e_data, "data_out", tg, 32'(data_out), 32'(e_data));
      chk(rd_valid == m_rdv, "rd_valid", "R8", 32'(rd_valid), 32'(m_rdv));
      if (m_rdv) chk(rd_data == m_rdd, "rd_data", "R8", 32'(rd_data), 32'(m_rdd));
      if (!rw_n && (prev_rw || addr_out != prev_addr)) begin wr_seen++; last_wr = addr_out; end
      if (data_oe && rw_n) last_park = addr_out;
      if (rd_valid) rd_seen++;
      if (busy) busy_after++;
      prev_rw = rw_n; prev_addr = addr_out;
    end
    tick++;
    e_clk = ((tick % 16) >= 8);
    q_clk = ((tick % 16) >= 4) && ((tick % 16) < 12);
    src_valid = (src_q.size() > 0) && (!gap_mode || ((tick / 16) % 3 != 1));
    src_data  = (src_q.size() > 0) ? src_q[0] : 8'h00;
    if (tick > 150000) begin
      miscompares++;
      $display("FAIL watchdog: actual tick %0d expected done earlier", tick);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic kick(input bit wr, input bit pre, input logic [1:0] sel,
                      input logic [15:0] a, input logic [3:0] len);
    @(negedge clk);
    start_wr = wr; start_pre = pre; park_sel = sel; start_addr = a; start_len = len;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_burst(input bit wr, input bit pre, input logic [1:0] sel,
                           input logic [15:0] a, input logic [3:0] len);
    int n;
    n = (len == 0) ? 16 : len;
    wr_seen = 0; rd_seen = 0;
    if (wr) for (int i = 0; i < n; i++) src_q.push_back(8'(i * 37) ^ a[7:0] ^ 8'hC3);
    kick(wr, pre, sel, a, len);
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
    if (wr) begin
      chk(wr_seen == n, "write count", "R9", 32'(wr_seen), 32'(n));
      chk(last_wr == 16'(a + n - 1), "last target", "R9", 32'(last_wr), 32'(a + n - 1));
    end else begin
      chk(rd_seen == n, "read count", "R8", 32'(rd_seen), 32'(n));
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(!bus_req && !busy && !done && rw_n && !data_oe && !src_ready && !rd_valid,
        "reset outputs", "R1", {bus_req, busy, done, rw_n, data_oe, src_ready, rd_valid}, 32'b0001000);
    rst_n = 1'b1;
    repeat (7) @(negedge clk);

    // R5 direct writes, steady stream
    run_burst(1, 0, 2'd0, 16'h1000, 4'd4);
    // R6 R7 R10 precharge with a gappy stream
    gap_mode = 1'b1;
    run_burst(1, 1, 2'd1, 16'h2340, 4'd3);
    chk(last_park == 16'hFFE0, "park address sel1", "R7", 32'(last_park), 32'hFFE0);
    // R9 length zero means sixteen, wrapping addresses; R3 start ignored mid-burst
    begin
      wr_seen = 0;
      for (int i = 0; i < 16; i++) src_q.push_back(8'(i + 8'h11));
      kick(1, 1, 2'd2, 16'hFFF8, 4'd0);
      repeat (100) @(negedge clk);
      kick(0, 0, 2'd0, 16'h0800, 4'd1);
      while (!done) @(negedge clk);
      repeat (2) @(negedge clk);
      chk(wr_seen == 16, "burst kept length", "R3", 32'(wr_seen), 32'd16);
      chk(last_wr == 16'h0007, "wrapped last target", "R9", 32'(last_wr), 32'h0007);
      chk(last_park == 16'hFFF0, "park address sel2", "R7", 32'(last_park), 32'hFFF0);
      busy_after = 0;
      repeat (40) @(negedge clk);
      chk(busy_after == 0, "no second burst", "R3", 32'(busy_after), 32'd0);
    end
    gap_mode = 1'b0;
    // R4 R8 reads with a late grant
    bus_grant = 1'b0;
    fork
      run_burst(0, 0, 2'd0, 16'h4A10, 4'd4);
      begin repeat (60) @(negedge clk); bus_grant = 1'b1; end
    join
    // R7 select 3 falls back to the I/O region
    run_burst(1, 1, 2'd3, 16'h0100, 4'd2);
    chk(last_park == 16'hFF00, "park address sel3", "R7", 32'(last_park), 32'hFF00);
    run_burst(1, 1, 2'd0, 16'h0200, 4'd1);
    chk(last_park == 16'hFF00, "park address sel0", "R7", 32'(last_park), 32'hFF00);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule